// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns parallel characters into a start/stop framed serial stream on a single line that rests high. A host writes a character into a one-entry holding register. When the shift stage is free, the block hands the character over, adds a low start bit, an optional ninth bit and a high stop bit, and sends the frame least significant bit first. Each bit lasts sixteen ticks of an oversampling clock. That clock is the module clock divided by a 13-bit divisor.

The holding register and the shift stage form a two-deep path. The host can therefore queue the next character while the current one is still on the line, and consecutive frames follow each other with no idle time. Two status flags show the progress of the path. One says the holding register is free again, which happens at hand-off. The other says the line has gone quiet after the last stop bit. Each flag has its own interrupt enable, and the enabled flags are merged into one interrupt output. A transmit enable gates the whole path. While it is low, the line is forced high, the frame in flight is dropped and the holding register is emptied.

Top module: `serial_tx_core`

## Requirements
- R1: After reset, `tx_line` is 1, `flag_hold_empty` is 1, `flag_tx_done` is 1 and no frame is in progress.
- R2: Every bit of a frame lasts exactly 16 × D module clocks. D is `cfg_divisor`, and a divisor of 0 acts as 1.
- R3: A frame is a start bit of 0, then data bits from `wr_data[0]` upward, then one stop bit of 1. The start bit appears on `tx_line` from the clock edge that hands the character to the shift stage.
- R4: With `cfg_nine_bit` = 0 the frame carries `wr_data[7:0]` and is 10 bits long; `cfg_parity_en` and `wr_data[8]` have no effect. With `cfg_nine_bit` = 1 a ninth bit follows bit 7 and the frame is 11 bits long.
- R5: In nine-bit mode the ninth bit is `wr_data[8]` when `cfg_parity_en` = 0. When parity is enabled it is the parity of `wr_data[7:0]`: with `cfg_parity_odd` = 0 it makes the count of ones even, and with 1 it makes the count odd.
- R6: An accepted write (`wr_en` high while `cfg_tx_en` is high) clears `flag_hold_empty` from the next cycle. If the shift stage is idle, the hand-off takes place one clock later and sets `flag_hold_empty` again.
- R7: Hand-off clears `flag_tx_done`. `flag_tx_done` sets when the stop bit ends and no character is waiting.
- R8: A character written while a frame is on the line starts its start bit on the same clock edge that ends the previous stop bit, with no idle bit time in between.
- R9: `irq` is 1 exactly when (`flag_hold_empty` and `cfg_irq_empty_en`) or (`flag_tx_done` and `cfg_irq_done_en`).
- R10: While `cfg_tx_en` is 0, `tx_line` is 1 and writes are ignored. At the next clock, a frame in progress is abandoned and the holding register is emptied; `flag_tx_done` keeps its value. After re-enable, the line stays idle until a new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | module clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_tx_en | input | 1 | transmit enable; gates the line and the data path |
| cfg_nine_bit | input | 1 | 0: 8-bit frame body, 1: 9-bit frame body |
| cfg_parity_en | input | 1 | in 9-bit mode, replace the ninth data bit by parity |
| cfg_parity_odd | input | 1 | parity sense: 0 even, 1 odd |
| cfg_irq_empty_en | input | 1 | interrupt enable for the holding-empty flag |
| cfg_irq_done_en | input | 1 | interrupt enable for the transmit-done flag |
| cfg_divisor | input | 13 | oversampling clock divisor |
| wr_en | input | 1 | one-cycle write strobe for the holding register |
| wr_data | input | 9 | character to send |
| tx_line | output | 1 | serial output, idles at 1 |
| flag_hold_empty | output | 1 | holding register can take a character |
| flag_tx_done | output | 1 | last frame has fully left the line |
| irq | output | 1 | merged interrupt request |

## Verification
A wrong bit counter or shift-stage state shows at the port within one frame. A bit may appear in the wrong slot, the stop bit may come too early, or the next start bit may not follow at once. Sampling `tx_line` at the middle of every bit exposes each of these. A fault in the divisor or oversampling count moves the bit edges by whole prescaler periods, and the same mid-bit samples catch the drift before the frame ends. Flag and hand-off errors are visible one clock after the write or after the final stop bit, where the bench checks both flags together with the interrupt they drive.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  // widest character: eight data bits plus the optional ninth bit
  localparam int unsigned CHAR_W  = 9;
  // start + body + stop for the widest frame
  localparam int unsigned FRAME_W = CHAR_W + 2;
  localparam int unsigned LEN_W   = $clog2(FRAME_W + 1);

  // parity over the low data bits; odd selects odd sense
  function automatic logic parity_bit(input logic [CHAR_W-2:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // frame image, bit 0 leaves first; unused high bits stay at the idle level
  function automatic logic [FRAME_W-1:0] build_frame(input logic [CHAR_W-1:0] d,
                                                    input logic nine,
                                                    input logic par_en,
                                                    input logic odd);
    logic [FRAME_W-1:0] f;
    f = '1;
    f[0] = 1'b0;
    f[CHAR_W-1:1] = d[CHAR_W-2:0];
    if (nine) f[CHAR_W] = par_en ? parity_bit(d[CHAR_W-2:0], odd) : d[CHAR_W-1];
    return f;
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input logic nine);
    return nine ? LEN_W'(FRAME_W) : LEN_W'(FRAME_W - 1);
  endfunction
endpackage

// File: rtl/serial_tx_baud.sv
module serial_tx_baud #(
  parameter int unsigned DIV_W = 13,
  parameter int unsigned OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             bit_end
);
  localparam int unsigned SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  logic [DIV_W-1:0] pre_q;
  logic [SUB_W-1:0] sub_q;
  logic [DIV_W-1:0] pre_last;
  logic             tick;

  assign pre_last = (divisor == '0) ? '0 : divisor - 1'b1;
  assign tick     = run && (pre_q == pre_last);
  assign bit_end  = tick && (sub_q == SUB_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (restart || !run) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/serial_tx_hold.sv
module serial_tx_hold #(
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (flush) begin
      full <= 1'b0;
    end else if (wr) begin
      data <= wr_data;
      full <= 1'b1;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_tx_shift.sv
module serial_tx_shift #(
  parameter int unsigned FRAME_W = 11,
  parameter int unsigned LEN_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               abort,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [LEN_W-1:0]   len_in,
  input  logic               bit_end,
  output logic               line_bit,
  output logic               busy,
  output logic               frame_end
);
  logic [FRAME_W-1:0] sh_q;
  logic [LEN_W-1:0]   left_q;

  assign frame_end = busy && bit_end && (left_q == LEN_W'(1));
  assign line_bit  = busy ? sh_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      busy   <= 1'b0;
    end else if (abort) begin
      sh_q   <= '1;
      left_q <= '0;
      busy   <= 1'b0;
    end else if (load) begin
      sh_q   <= frame_in;
      left_q <= len_in;
      busy   <= 1'b1;
    end else if (frame_end) begin
      sh_q   <= '1;
      left_q <= '0;
      busy   <= 1'b0;
    end else if (busy && bit_end) begin
      sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
  import serial_tx_pkg::*;
#(
  parameter int unsigned DIV_W = 13,
  parameter int unsigned OVS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_tx_en,
  input  logic              cfg_nine_bit,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic              cfg_irq_empty_en,
  input  logic              cfg_irq_done_en,
  input  logic [DIV_W-1:0]  cfg_divisor,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_data,
  output logic              tx_line,
  output logic              flag_hold_empty,
  output logic              flag_tx_done,
  output logic              irq
);
  logic              hold_full;
  logic [CHAR_W-1:0] hold_data;
  logic              busy;
  logic              line_bit;
  logic              bit_end;
  logic              frame_end;
  logic              load_evt;
  logic              done_q;

  // hand-off: shifter idle, or its stop bit ends this very cycle
  assign load_evt = cfg_tx_en && hold_full && (!busy || frame_end);

  serial_tx_hold #(.DATA_W(CHAR_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (!cfg_tx_en),
    .wr      (wr_en),
    .wr_data (wr_data),
    .take    (load_evt),
    .full    (hold_full),
    .data    (hold_data)
  );

  serial_tx_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load_evt),
    .run     (busy),
    .divisor (cfg_divisor),
    .bit_end (bit_end)
  );

  serial_tx_shift #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (!cfg_tx_en),
    .load      (load_evt),
    .frame_in  (build_frame(hold_data, cfg_nine_bit, cfg_parity_en, cfg_parity_odd)),
    .len_in    (frame_len(cfg_nine_bit)),
    .bit_end   (bit_end),
    .line_bit  (line_bit),
    .busy      (busy),
    .frame_end (frame_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      done_q <= 1'b1;
    else if (load_evt)               done_q <= 1'b0;
    else if (frame_end && cfg_tx_en) done_q <= 1'b1;
  end

  assign tx_line         = cfg_tx_en ? line_bit : 1'b1;
  assign flag_hold_empty = !hold_full;
  assign flag_tx_done    = done_q;
  assign irq             = (flag_hold_empty && cfg_irq_empty_en) ||
                           (flag_tx_done && cfg_irq_done_en);
endmodule

// File: rtl/serial_tx_checker.sv
module serial_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_tx_en,
  input logic cfg_irq_empty_en,
  input logic cfg_irq_done_en,
  input logic wr_en,
  input logic tx_line,
  input logic flag_hold_empty,
  input logic flag_tx_done,
  input logic irq,
  input logic load_evt,
  input logic frame_end
);
  assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_tx_en |-> tx_line);

  assert_write_clears_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cfg_tx_en) |=> !flag_hold_empty);

  assert_handoff_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !wr_en) |=> (flag_hold_empty && !flag_tx_done));

  assert_start_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (!tx_line || !cfg_tx_en));

  assert_done_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && cfg_tx_en && !load_evt) |=> flag_tx_done);

  assert_no_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && cfg_tx_en && !flag_hold_empty) |-> load_evt);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_irq_empty_en && !cfg_irq_done_en) |-> !irq);
endmodule

bind serial_tx_core serial_tx_checker u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cfg_tx_en        (cfg_tx_en),
  .cfg_irq_empty_en (cfg_irq_empty_en),
  .cfg_irq_done_en  (cfg_irq_done_en),
  .wr_en            (wr_en),
  .tx_line          (tx_line),
  .flag_hold_empty  (flag_hold_empty),
  .flag_tx_done     (flag_tx_done),
  .irq              (irq),
  .load_evt         (load_evt),
  .frame_end        (frame_end)
);

// File: tb/test_serial_tx_core.sv
`timescale 1ns/1ps
module test_serial_tx_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_tx_en = 1'b1;
  logic        cfg_nine_bit = 1'b0;
  logic        cfg_parity_en = 1'b0;
  logic        cfg_parity_odd = 1'b0;
  logic        cfg_irq_empty_en = 1'b1;
  logic        cfg_irq_done_en = 1'b1;
  logic [12:0] cfg_divisor = 13'd1;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_data = '0;
  logic        tx_line, flag_hold_empty, flag_tx_done, irq;

  int tests = 0;
  int failed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  serial_tx_core i_serial_tx_core (
    .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .cfg_nine_bit(cfg_nine_bit),
    .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
    .cfg_irq_empty_en(cfg_irq_empty_en), .cfg_irq_done_en(cfg_irq_done_en),
    .cfg_divisor(cfg_divisor), .wr_en(wr_en), .wr_data(wr_data),
    .tx_line(tx_line), .flag_hold_empty(flag_hold_empty),
    .flag_tx_done(flag_tx_done), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_flags(input logic e_empty, input logic e_done, input string req);
    check(req, flag_hold_empty, e_empty);
    check(req, flag_tx_done, e_done);
    check("R9 irq", irq, (e_empty & cfg_irq_empty_en) | (e_done & cfg_irq_done_en));
  endtask

  // from the negedge after edge E, move to the negedge after edge E+n
  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // expected line value of frame slot k, worked out by counting ones
  function automatic logic exp_bit(input logic [8:0] d, input logic nine,
                                   input logic pe, input logic odd, input int k);
    int ones;
    ones = 0;
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    if (k == 9 && nine) begin
      if (!pe) return d[8];
      for (int i = 0; i < 8; i++) ones += int'(d[i]);
      return odd ? (ones % 2 == 0) : (ones % 2 == 1);
    end
    return 1'b1;
  endfunction

  // one write strobe; ends at the negedge after the capturing edge
  task automatic write_char(input logic [8:0] d);
    wr_en = 1'b1;
    wr_data = d;
    wait_cyc(1);
    wr_en = 1'b0;
  endtask

  // entered at the negedge after the hand-off edge; leaves mid stop bit
  task automatic run_frame(input logic [8:0] d, input int de, input bit inj,
                           input logic [8:0] inj_d);
    int len;
    int adj;
    len = cfg_nine_bit ? 11 : 10;
    adj = 0;
    check("R3 start at hand-off", tx_line, 1'b0);
    check_flags(1'b1, 1'b0, "R7 hand-off flags");
    for (int k = 0; k < len; k++) begin
      wait_cyc(((k == 0) ? 8 * de : 16 * de) - adj);
      adj = 0;
      check((k == 9 && cfg_nine_bit) ? "R5 ninth bit" : "R2 R3 R4 mid-bit", tx_line,
            exp_bit(d, cfg_nine_bit, cfg_parity_en, cfg_parity_odd, k));
      if (k == 0 && inj) begin
        write_char(inj_d);
        adj = 1;
        check_flags(1'b0, 1'b0, "R6 queued write");
      end
    end
  endtask

  task automatic send(input logic [8:0] d, input int div, input bit inj, input logic [8:0] d2);
    int de;
    cfg_divisor = 13'(div);
    de = (div == 0) ? 1 : div;
    write_char(d);
    check("R6 write clears empty", flag_hold_empty, 1'b0);
    wait_cyc(1);
    run_frame(d, de, inj, d2);
    wait_cyc(8 * de);
    if (inj) run_frame(d2, de, 1'b0, '0);  // R8: start bit right at stop end
    if (inj) wait_cyc(8 * de);
    check_flags(1'b1, 1'b1, "R7 done after stop");
    check("R3 idle line", tx_line, 1'b1);
  endtask

  initial begin
    void'($urandom(32'h5eed_0a17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 line", tx_line, 1'b1);
    check_flags(1'b1, 1'b1, "R1 flags");

    // directed: 8-bit 0x41, divisor 1
    cfg_nine_bit = 0; cfg_parity_en = 0;
    send(9'h041, 1, 1'b0, '0);
    // R4: parity enable and bit 8 ignored in 8-bit mode
    cfg_parity_en = 1; cfg_parity_odd = 1;
    send(9'h1C3, 2, 1'b0, '0);
    // R5: 9-bit, odd parity; R2: divisor 0 acts as 1
    cfg_nine_bit = 1;
    send(9'h021, 0, 1'b0, '0);
    // R5: 9-bit data without parity, even parity back-to-back (R8)
    cfg_parity_en = 0;
    send(9'h155, 3, 1'b1, 9'h0AA);
    cfg_parity_en = 1; cfg_parity_odd = 0;
    cfg_irq_empty_en = 0;
    send(9'h0FF, 1, 1'b1, 9'h001);

    // R10: disable mid-frame with a character queued
    cfg_nine_bit = 0; cfg_divisor = 13'd2;
    cfg_irq_empty_en = 1; cfg_irq_done_en = 0;
    write_char(9'h033);
    wait_cyc(1);
    wait_cyc(20);
    write_char(9'h0CC);
    check("R6 queued", flag_hold_empty, 1'b0);
    cfg_tx_en = 1'b0;
    #1;
    check("R10 line forced idle", tx_line, 1'b1);
    wait_cyc(1);
    check_flags(1'b1, 1'b0, "R10 abandon");
    write_char(9'h0F0);
    check("R10 write ignored", flag_hold_empty, 1'b1);
    cfg_tx_en = 1'b1;
    begin
      int bad;
      bad = 0;
      for (int c = 0; c < 100; c++) begin
        wait_cyc(1);
        if (tx_line !== 1'b1) bad++;
      end
      check("R10 stays idle after re-enable", bad, 0);
    end
    check_flags(1'b1, 1'b0, "R10 flags after re-enable");
    send(9'h05A, 2, 1'b0, '0);

    // constrained random frames
    for (int n = 0; n < 20; n++) begin
      cfg_nine_bit     = $urandom % 2;
      cfg_parity_en    = $urandom % 2;
      cfg_parity_odd   = $urandom % 2;
      cfg_irq_empty_en = $urandom % 2;
      cfg_irq_done_en  = $urandom % 2;
      send(9'($urandom), int'($urandom % 4), bit'($urandom % 2), 9'($urandom));
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end
endmodule